// File: doc/BRIEF.md
# Timer Compare Unit with Period Register

An 8-bit up-counter, advancing on a count-enable input, is watched by two compare channels and bounded by a period register. Each compare channel raises a sticky flag when the counter reaches its value by counting. The flag becomes visible one cycle after the counter holds the matching value. A third register holds the top of the count. When the counter equals it and counts, it returns to zero instead of incrementing.

Software reaches the counter, the two compare values, the period, the flags and the interrupt enables through a simple register bus. The bus has a write strobe, a 3-bit address, write data, and read data that is decoded combinationally. Loading the counter, or a compare value, never produces a match by itself. Only a value reached by counting is compared. Each flag drives a level interrupt output, gated by its own enable bit.

Top module: `tmr_cmp_top`

## Requirements
- R1: After reset the counter, both compare values, the flags and the interrupt enables read 0x00, the period reads 0xFF and both interrupt outputs are low.
- R2: The counter goes up by one on each clock with `cnt_en` high and holds its value with `cnt_en` low.
- R3: When the counter equals the period value (address 3) and `cnt_en` is high, the next counter value is 0x00. A compare value of 0x00 then matches.
- R4: Compare A (address 1) and compare B (address 2) store and read back any 8-bit value. A write of 0, 1 or 2 to the period (address 3) stores 3. Larger writes are stored as written.
- R5: When counting makes the counter equal compare A, flag bit 0 (address 4) is set. Compare B sets flag bit 1 in the same way. Each flag bit is set one cycle after the counter shows the matching value, not in that cycle.
- R6: A counter write (address 0) that makes the counter equal a compare value sets no flag. A compare write that makes a compare value equal the counter sets no flag. This holds even when the compare write lands on the same edge as a count.
- R7: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A match and a clear on the same edge leave the flag set.
- R8: Interrupt enable bit 0 / bit 1 (address 5) gate flag bit 0 / bit 1 onto `irq[0]` / `irq[1]`, as level outputs.
- R9: A counter write takes priority over counting on the same edge. The counter then holds the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Counter advances while high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 counter, 1 compare A, 2 compare B, 3 period, 4 flags, 5 enables) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Level interrupts, bit 0 for compare A, bit 1 for compare B |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a flag being set by a match and the same flag being cleared by a bus write. The bench lets the counter count onto compare A. In that same cycle it drives a write of 1 to flag bit 0, and it judges the result by reading the flag back as set.

The second pair is counting and a register write. In one case a compare value is written to the value the counter reaches on that edge, and the flags must stay clear. In the other case the counter is written while `cnt_en` is high, and the counter must read the written value rather than an increment.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned ADR_W = 3;
  localparam int unsigned CH_N  = 2;

  typedef logic [ADR_W-1:0] adr_t;

  localparam adr_t A_CNT  = 3'd0;
  localparam adr_t A_CMP0 = 3'd1;  // channel n at A_CMP0 + n
  localparam adr_t A_PER  = 3'd3;
  localparam adr_t A_FLG  = 3'd4;
  localparam adr_t A_IEN  = 3'd5;
endpackage

// File: rtl/tmr_rst_sync.sv
`timescale 1ns/1ps
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         cnt_en,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt_q,
  output logic         adv_q
);
  logic [W-1:0] cnt_d;
  logic         cnt_ce;
  logic         adv_d;
  logic         at_top;

  assign at_top = (cnt_q == per);
  assign cnt_ce = ld | cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    adv_d = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
    end else if (cnt_en) begin
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
      adv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_q <= 1'b0;
    else        adv_q <= adv_d;
  end
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned PER_MIN = 3,
  parameter logic [W-1:0] PER_RST = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  adr_t                   addr,
  input  logic [W-1:0]           wdata,
  output logic [CH_N-1:0][W-1:0] cmp_q,
  output logic [CH_N-1:0]        cmp_wr_q,
  output logic [W-1:0]           per_q,
  output logic [CH_N-1:0]        ien_q
);
  localparam logic [W-1:0] PER_FLOOR = W'(PER_MIN);

  logic [CH_N-1:0][W-1:0] cmp_d;
  logic [CH_N-1:0]        cmp_hit;
  logic [W-1:0]           per_d;
  logic                   per_ce;
  logic                   ien_ce;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_hit
    assign cmp_hit[ch] = we && (addr == A_CMP0 + adr_t'(ch));
  end

  always_comb begin
    cmp_d = cmp_q;
    for (int ch = 0; ch < CH_N; ch++) begin
      if (cmp_hit[ch]) cmp_d[ch] = wdata;
    end
  end

  assign per_ce = we && (addr == A_PER);
  assign ien_ce = we && (addr == A_IEN);
  assign per_d  = (wdata < PER_FLOOR) ? PER_FLOOR : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_wr_q <= '0;
    else        cmp_wr_q <= cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= PER_RST;
    else if (per_ce) per_q <= per_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_ce) ien_q <= wdata[CH_N-1:0];
  end
endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           cnt,
  input  logic                   adv,
  input  logic [CH_N-1:0][W-1:0] cmp,
  input  logic [CH_N-1:0]        cmp_wr,
  input  logic [CH_N-1:0]        clr,
  input  logic [CH_N-1:0]        ien,
  output logic [CH_N-1:0]        flag_q,
  output logic [CH_N-1:0]        irq
);
  logic [CH_N-1:0] evt;
  logic [CH_N-1:0] flag_d;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    // a value reached by counting, against a compare value not just rewritten
    assign evt[ch]    = adv && !cmp_wr[ch] && (cnt == cmp[ch]);
    assign flag_d[ch] = evt[ch] | (flag_q[ch] & ~clr[ch]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q & ien;
endmodule

// File: rtl/tmr_cmp_top.sv
`timescale 1ns/1ps
module tmr_cmp_top
  import tmr_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned PER_MIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic [CH_N-1:0] irq
);
  logic                   rst_sync_n;
  logic [W-1:0]           cnt_q;
  logic                   adv_q;
  logic                   cnt_ld;
  logic [CH_N-1:0][W-1:0] cmp_q;
  logic [CH_N-1:0]        cmp_wr_q;
  logic [W-1:0]           per_q;
  logic [CH_N-1:0]        ien_q;
  logic [CH_N-1:0]        flag_q;
  logic [CH_N-1:0]        flag_clr;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign cnt_ld   = bus_we && (bus_addr == A_CNT);
  assign flag_clr = (bus_we && (bus_addr == A_FLG)) ? bus_wdata[CH_N-1:0] : '0;

  tmr_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .ld(cnt_ld), .ld_val(bus_wdata),
    .cnt_en(cnt_en), .per(per_q), .cnt_q(cnt_q), .adv_q(adv_q)
  );

  tmr_regs #(.W(W), .PER_MIN(PER_MIN), .PER_RST('1)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .cmp_q(cmp_q), .cmp_wr_q(cmp_wr_q),
    .per_q(per_q), .ien_q(ien_q)
  );

  tmr_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .cnt(cnt_q), .adv(adv_q), .cmp(cmp_q),
    .cmp_wr(cmp_wr_q), .clr(flag_clr), .ien(ien_q), .flag_q(flag_q),
    .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT:   bus_rdata = cnt_q;
      A_PER:   bus_rdata = per_q;
      A_FLG:   bus_rdata = {{(W-CH_N){1'b0}}, flag_q};
      A_IEN:   bus_rdata = {{(W-CH_N){1'b0}}, ien_q};
      default: begin
        for (int ch = 0; ch < CH_N; ch++) begin
          if (bus_addr == A_CMP0 + adr_t'(ch)) bus_rdata = cmp_q[ch];
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_cmp_chk.sv
`timescale 1ns/1ps
module tmr_cmp_chk
  import tmr_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned PER_MIN = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cnt_en,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [W-1:0]    bus_wdata,
  input logic [W-1:0]    cnt,
  input logic [W-1:0]    per,
  input logic [W-1:0]    cmp_a,
  input logic [CH_N-1:0] flags
);
  logic ld;
  logic fclr0;
  assign ld    = bus_we && (bus_addr == A_CNT);
  assign fclr0 = bus_we && (bus_addr == A_FLG) && bus_wdata[0];

  assert_period_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per >= W'(PER_MIN));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !cnt_en) |=> $stable(cnt));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_en && cnt == per) |=> (cnt == '0));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(bus_wdata)));

  assert_flag_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(cnt) == $past(cmp_a)));

  assert_no_load_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld) |=> (!$rose(flags[0]) && !$rose(flags[1])));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !fclr0) |=> flags[0]);
endmodule

bind tmr_cmp_top tmr_cmp_chk #(.W(W), .PER_MIN(PER_MIN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q), .per(per_q),
  .cmp_a(cmp_q[0]), .flags(flag_q)
);

// File: tb/tmr_cmp_top_tb.sv
`timescale 1ns/1ps
module tmr_cmp_top_tb;
  logic       clk;
  logic       rst_n;
  logic       cnt_en;
  logic       bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;

  tmr_cmp_top u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [3:0] OP_WR  = 4'd0;
  localparam logic [3:0] OP_RD  = 4'd1;
  localparam logic [3:0] OP_RUN = 4'd2;
  localparam logic [3:0] OP_IDL = 4'd3;
  localparam logic [3:0] OP_IRQ = 4'd4;
  localparam int NV = 49;

  // {op, requirement number, address, data or expected value}
  localparam logic [23:0] TBL [0:NV-1] = '{
    {OP_RD, 4'd1, 8'd0, 8'h00}, {OP_RD, 4'd1, 8'd1, 8'h00},
    {OP_RD, 4'd1, 8'd2, 8'h00}, {OP_RD, 4'd1, 8'd3, 8'hFF},
    {OP_RD, 4'd1, 8'd4, 8'h00}, {OP_RD, 4'd1, 8'd5, 8'h00},
    {OP_IRQ,4'd1, 8'd0, 8'h00},
    {OP_WR, 4'd4, 8'd1, 8'h05}, {OP_WR, 4'd4, 8'd2, 8'h0A},
    {OP_RD, 4'd4, 8'd1, 8'h05}, {OP_RD, 4'd4, 8'd2, 8'h0A},
    {OP_WR, 4'd4, 8'd3, 8'h01}, {OP_RD, 4'd4, 8'd3, 8'h03},
    {OP_WR, 4'd4, 8'd3, 8'h02}, {OP_RD, 4'd4, 8'd3, 8'h03},
    {OP_WR, 4'd4, 8'd3, 8'h00}, {OP_RD, 4'd4, 8'd3, 8'h03},
    {OP_WR, 4'd4, 8'd3, 8'h0C}, {OP_RD, 4'd4, 8'd3, 8'h0C},
    {OP_RUN,4'd2, 8'd0, 8'h03}, {OP_RD, 4'd2, 8'd0, 8'h03},
    {OP_RD, 4'd5, 8'd4, 8'h00},
    {OP_RUN,4'd5, 8'd0, 8'h02}, {OP_RD, 4'd5, 8'd4, 8'h00},
    {OP_RD, 4'd5, 8'd4, 8'h01}, {OP_RD, 4'd2, 8'd0, 8'h05},
    {OP_WR, 4'd7, 8'd4, 8'h02}, {OP_RD, 4'd7, 8'd4, 8'h01},
    {OP_WR, 4'd7, 8'd4, 8'h01}, {OP_RD, 4'd7, 8'd4, 8'h00},
    {OP_WR, 4'd6, 8'd0, 8'h0A}, {OP_IDL,4'd6, 8'd0, 8'h03},
    {OP_RD, 4'd6, 8'd4, 8'h00}, {OP_RD, 4'd9, 8'd0, 8'h0A},
    {OP_WR, 4'd6, 8'd1, 8'h0A}, {OP_IDL,4'd6, 8'd0, 8'h02},
    {OP_RD, 4'd6, 8'd4, 8'h00},
    {OP_WR, 4'd3, 8'd1, 8'h00}, {OP_RUN,4'd3, 8'd0, 8'h03},
    {OP_RD, 4'd3, 8'd0, 8'h00}, {OP_RD, 4'd3, 8'd4, 8'h01},
    {OP_IRQ,4'd8, 8'd0, 8'h00}, {OP_WR, 4'd8, 8'd5, 8'h01},
    {OP_IRQ,4'd8, 8'd0, 8'h01}, {OP_RD, 4'd8, 8'd5, 8'h01},
    {OP_WR, 4'd8, 8'd5, 8'h03}, {OP_IRQ,4'd8, 8'd0, 8'h01},
    {OP_WR, 4'd8, 8'd4, 8'h01}, {OP_IRQ,4'd8, 8'd0, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 cnt_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // table: R1 reset, R2 count/hold, R3 wrap, R4 clamp, R5 flag delay,
    // R6 write never matches, R7 clear, R8 irq gating, R9 loaded value
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      string tag;
      op  = TBL[i][23:20];
      tag = $sformatf("R%0d vec%0d", TBL[i][19:16], i);
      case (op)
        OP_WR:  wr(TBL[i][10:8], TBL[i][7:0]);
        OP_RD:  rd(TBL[i][10:8], tag, TBL[i][7:0]);
        OP_RUN: run(int'(TBL[i][7:0]));
        OP_IDL: repeat (int'(TBL[i][7:0])) @(posedge clk);
        default: begin
          @(negedge clk);
          #1 check(tag, {6'd0, irq}, TBL[i][7:0]);
        end
      endcase
    end

    // R7: match and clear on the same edge, set wins
    wr(3'd1, 8'h03);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (3) @(posedge clk);
    #1 cnt_en = 1'b0;
    bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h01;
    @(posedge clk);
    #1 bus_we = 1'b0;
    rd(3'd4, "R7 set wins", 8'h01);
    #1 check("R8 irq with set", {6'd0, irq}, 8'h01);
    wr(3'd4, 8'h03);
    rd(3'd4, "R7 cleared", 8'h00);

    // R6: compare written to the value reached on the same edge
    @(negedge clk);
    cnt_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h04;
    @(posedge clk);
    #1 begin cnt_en = 1'b0; bus_we = 1'b0; end
    @(posedge clk);
    rd(3'd4, "R6 compare write while counting", 8'h00);
    rd(3'd0, "R2 counter after step", 8'h04);

    // R9: counter write with cnt_en high
    @(negedge clk);
    cnt_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h20;
    @(posedge clk);
    #1 begin cnt_en = 1'b0; bus_we = 1'b0; end
    rd(3'd0, "R9 load over count", 8'h20);

    // R5: channel B
    wr(3'd2, 8'h22);
    run(2);
    rd(3'd4, "R5 B before delay", 8'h00);
    rd(3'd4, "R5 B flag", 8'h02);
    #1 check("R8 irq B", {6'd0, irq}, 8'h02);

    // R1: reset in mid-operation
    @(negedge clk) rst_n = 1'b0;
    #1;
    bus_addr = 3'd0; #1 check("R1 counter after reset", bus_rdata, 8'h00);
    bus_addr = 3'd2; #1 check("R1 compare B after reset", bus_rdata, 8'h00);
    bus_addr = 3'd3; #1 check("R1 period after reset", bus_rdata, 8'hFF);
    bus_addr = 3'd4; #1 check("R1 flags after reset", bus_rdata, 8'h00);
    check("R1 irq after reset", {6'd0, irq}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    rd(3'd5, "R1 enables after reset", 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule